// File: doc/BRIEF.md
# Random Dummy-Instruction Injection Stage

This stage sits between instruction fetch and decode. Before each real instruction it can issue zero, one or two inert instructions. The number of inert instructions is drawn from an external random bit source. This breaks the fixed timing link between the instruction stream and the work the pipeline does, one instruction at a time. Both sides use a valid/ready handshake. Downstream sees a stream that mixes real instructions with inert fillers. Each filler is marked by a flag, so retirement counting can leave it out.

The stage does not store the real instruction. It keeps the upstream handshake stalled while the fillers go out. The real instruction is accepted only in the cycle it is itself handed downstream. A branch flush drops the instruction on offer and any fillers still owed. When the countermeasure is off, the stage is a plain wire with no added latency.

Top module: `jitter_nop_stage`

## Requirements
- R1: Each real instruction is preceded downstream by between zero and MAX_DUMMY (default 2) filler handshakes, and never more.
- R2: The filler count for an instruction is the value of the 2-bit random input when that instruction is first offered. The values 0, 1 and 2 give that many fillers. The value 3 gives HIGH_MAP fillers (default 1).
- R3: A filler appears as out_instr = 0x00000013 (add-immediate of zero into the zero register) with out_dummy = 1. A real instruction appears unchanged with out_dummy = 0.
- R4: While fillers are owed, in_ready stays low. in_ready is high only in the cycle the real instruction is offered downstream and out_ready is high.
- R5: While downstream stalls (out_valid = 1, out_ready = 0), the offered word and its out_dummy flag stay stable. A change of the random input after the first offer does not change that instruction's filler count.
- R6: While flush is high, out_valid is 0 and in_ready is 1, so the offered instruction is dropped. Any fillers still owed are discarded. The next instruction draws a fresh count.
- R7: With en low and flush low, out_valid = in_valid, out_instr = in_instr, in_ready = out_ready and out_dummy = 0, all in the same cycle.
- R8: After reset no fillers are owed. out_valid is 0 while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Turns filler insertion on |
| flush | input | 1 | Branch flush: drop offered instruction and owed fillers |
| rnd | input | 2 | Random bits choosing the filler count |
| in_valid | input | 1 | Upstream instruction valid |
| in_instr | input | 32 | Upstream instruction word |
| in_ready | output | 1 | Upstream instruction accepted |
| out_valid | output | 1 | Downstream word valid |
| out_instr | output | 32 | Downstream word, real or filler |
| out_dummy | output | 1 | Downstream word is a filler |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Several properties are checked on every cycle:
- the cap on consecutive filler handshakes;
- the range of the drawn count;
- that upstream is never accepted while a filler is on offer;
- the bypass relation with en low;
- the flush outputs;
- stability of the offered word under stall.

Other behaviour needs the bench's scenarios:
- that the filler count matches the random value of the first offer;
- the folding of the value 3;
- that a flush leaves no owed fillers for the next instruction.

The bench sweeps every random value against several stall lengths to show these.

// File: rtl/jitter_pkg.sv
package jitter_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam logic [INSTR_W-1:0] INERT_OP = 32'h0000_0013;

  // raw draw above the cap is folded onto a configured value
  function automatic int unsigned fold_draw(input int unsigned raw,
                                            input int unsigned cap,
                                            input int unsigned high_map);
    return (raw > cap) ? high_map : raw;
  endfunction
endpackage

// File: rtl/nop_count_pick.sv
module nop_count_pick
  import jitter_pkg::*;
#(
  parameter int unsigned RND_W     = 2,
  parameter int unsigned MAX_DUMMY = 2,
  parameter int unsigned HIGH_MAP  = 1,
  parameter bit          REDRAW    = 1'b0,
  parameter int unsigned CNT_W     = 2
) (
  input  logic [RND_W-1:0] rnd,
  output logic [CNT_W-1:0] count,
  output logic             usable
);
  generate
    if (REDRAW) begin : g_redraw
      // out-of-range draws are rejected and retried next cycle
      assign usable = (32'(rnd) <= MAX_DUMMY);
      assign count  = usable ? CNT_W'(rnd) : '0;
    end else begin : g_fold
      assign usable = 1'b1;
      assign count  = CNT_W'(fold_draw(32'(rnd), MAX_DUMMY, HIGH_MAP));
    end
  endgenerate

  always_comb begin
    if (!$isunknown(count))
      AST_COUNT_CAP: assert (32'(count) <= MAX_DUMMY) else $error("count above cap"); // R2
  end
endmodule

// File: rtl/nop_seq_ctrl.sv
module nop_seq_ctrl #(
  parameter int unsigned MAX_DUMMY = 2,
  parameter int unsigned CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [CNT_W-1:0] draw_cnt,
  input  logic             draw_ok,
  output logic             emit_valid,
  output logic             emit_dummy,
  output logic             hs_orig,
  output logic             hs_dummy
);
  localparam int unsigned RUN_W = CNT_W + 1;

  logic             drawn;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] cnt_now;
  logic             have;
  logic             active;
  logic             hs;

  assign active     = en & ~flush;
  assign cnt_now    = drawn ? rem : draw_cnt;
  assign have       = drawn | draw_ok;
  assign emit_valid = active & in_valid & have;
  assign emit_dummy = (cnt_now != '0);
  assign hs         = emit_valid & out_ready;
  assign hs_dummy   = hs & emit_dummy;
  assign hs_orig    = hs & ~emit_dummy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drawn <= 1'b0;
      rem   <= '0;
    end else if (!active || hs_orig) begin
      drawn <= 1'b0;
      rem   <= '0;
    end else if (in_valid && have) begin
      // lock the draw at first offer; count down on each filler taken
      drawn <= 1'b1;
      rem   <= hs_dummy ? cnt_now - 1'b1 : cnt_now;
    end
  end

  // fillers taken since the last real instruction, flush or disable
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (!active || hs_orig) run_len <= '0;
    else if (hs_dummy) run_len <= run_len + 1'b1;
  end

  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_len) <= MAX_DUMMY) else $error("filler run too long"); // R1
endmodule

// File: rtl/jitter_nop_stage.sv
module jitter_nop_stage
  import jitter_pkg::*;
#(
  parameter int unsigned RND_W     = 2,
  parameter int unsigned MAX_DUMMY = 2,
  parameter int unsigned HIGH_MAP  = 1,
  parameter bit          REDRAW    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               flush,
  input  logic [RND_W-1:0]   rnd,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               in_ready,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  output logic               out_dummy,
  input  logic               out_ready
);
  localparam int unsigned CNT_W = $clog2(MAX_DUMMY + 1);

  logic [CNT_W-1:0] draw_cnt;
  logic             draw_ok;
  logic             emit_valid;
  logic             emit_dummy;
  logic             hs_orig;
  logic             hs_dummy;

  nop_count_pick #(
    .RND_W(RND_W), .MAX_DUMMY(MAX_DUMMY), .HIGH_MAP(HIGH_MAP),
    .REDRAW(REDRAW), .CNT_W(CNT_W)
  ) u_pick (
    .rnd(rnd), .count(draw_cnt), .usable(draw_ok)
  );

  nop_seq_ctrl #(.MAX_DUMMY(MAX_DUMMY), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .flush(flush),
    .in_valid(in_valid), .out_ready(out_ready),
    .draw_cnt(draw_cnt), .draw_ok(draw_ok),
    .emit_valid(emit_valid), .emit_dummy(emit_dummy),
    .hs_orig(hs_orig), .hs_dummy(hs_dummy)
  );

  always_comb begin
    if (flush) begin
      out_valid = 1'b0;
      out_dummy = 1'b0;
      in_ready  = 1'b1;
    end else if (en) begin
      out_valid = emit_valid;
      out_dummy = emit_valid & emit_dummy;
      in_ready  = hs_orig;
    end else begin
      out_valid = in_valid;
      out_dummy = 1'b0;
      in_ready  = out_ready;
    end
    out_instr = out_dummy ? INERT_OP : in_instr;
  end

  AST_FILLER_BLOCKS_UPSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
    out_dummy |-> !in_ready) else $error("upstream taken during filler"); // R4
  AST_FILLER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dummy) |-> (out_instr == INERT_OP)) else $error("bad filler word"); // R3
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush) |-> (out_valid == in_valid && in_ready == out_ready && !out_dummy))
    else $error("bypass broken"); // R7
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && in_ready)) else $error("flush not dropping"); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flush && out_valid && !out_ready) |=>
      (!en || flush || (out_valid && $stable(out_dummy)))) else $error("stall not held"); // R5
  AST_FILLER_HS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    hs_dummy |-> (out_valid && out_dummy && out_ready)) else $error("filler handshake mismatch"); // R1
endmodule

// File: tb/jitter_nop_stage_bench.sv
`timescale 1ns/1ps
module jitter_nop_stage_bench;
  import jitter_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        flush = 1'b0;
  logic [1:0]  rnd = 2'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = 32'h0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_instr;
  logic        out_dummy;
  logic        out_ready = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  jitter_nop_stage u_jitter_nop_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .rnd(rnd),
    .in_valid(in_valid), .in_instr(in_instr), .in_ready(in_ready),
    .out_valid(out_valid), .out_instr(out_instr), .out_dummy(out_dummy),
    .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected filler count from the requirement (R2): 0,1,2 direct, 3 -> 1
  function automatic int exp_fill(input int r);
    return (r == 3) ? 1 : r;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_instr(input logic [31:0] ins, input int r, input int stall, input int r_alt);
    int e;
    e = exp_fill(r);
    in_valid = 1'b1; in_instr = ins; rnd = 2'(r);
    for (int k = 0; k <= e; k++) begin
      for (int s = 0; s < stall; s++) begin
        out_ready = 1'b0;
        @(negedge clk);
        chk("R5 stall valid", {31'b0, out_valid}, 32'd1);
        chk("R5 stall dummy", {31'b0, out_dummy}, {31'b0, (k < e)});
        chk("R4 stall in_ready", {31'b0, in_ready}, 32'd0);
        step();
        rnd = 2'(r_alt);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk("R1 valid", {31'b0, out_valid}, 32'd1);
      chk("R3 dummy flag", {31'b0, out_dummy}, {31'b0, (k < e)});
      chk("R3 word", out_instr, (k < e) ? INERT_OP : ins);
      chk("R4 in_ready", {31'b0, in_ready}, {31'b0, (k == e)});
      step();
      rnd = 2'(r_alt);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2;
    @(negedge clk);
    chk("R8 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R8 reset out_dummy", {31'b0, out_dummy}, 32'd0);
    repeat (2) step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk("R8 idle out_valid", {31'b0, out_valid}, 32'd0);
    step();

    // R1 R2 R3 R4 R5 sweep: every random value against stall lengths
    for (int r = 0; r < 4; r++)
      for (int st = 0; st < 3; st++)
        run_instr(32'h1000_0000 + 32'(r * 16 + st), r, st, (r + 1) % 4);

    // back-to-back instructions with no idle cycle
    for (int r = 3; r >= 0; r--)
      run_instr(32'h2000_0000 + 32'(r), r, 0, 3 - r);

    // R6 flush discards owed fillers
    in_valid = 1'b1; in_instr = 32'hAAAA_0001; rnd = 2'd2; out_ready = 1'b1;
    @(negedge clk);
    chk("R6 pre-flush filler", {31'b0, out_dummy}, 32'd1);
    step();
    flush = 1'b1;
    @(negedge clk);
    chk("R6 flush out_valid", {31'b0, out_valid}, 32'd0);
    chk("R6 flush in_ready", {31'b0, in_ready}, 32'd1);
    step();
    flush = 1'b0; in_instr = 32'hBBBB_0002; rnd = 2'd0;
    @(negedge clk);
    chk("R6 fresh draw dummy", {31'b0, out_dummy}, 32'd0);
    chk("R6 fresh draw word", out_instr, 32'hBBBB_0002);
    chk("R6 fresh draw in_ready", {31'b0, in_ready}, 32'd1);
    step();
    in_valid = 1'b0;

    // R7 bypass with en low
    en = 1'b0; rnd = 2'd2;
    for (int i = 0; i < 8; i++) begin
      in_valid = i[0]; out_ready = i[1]; in_instr = 32'hC0DE_0000 + 32'(i);
      @(negedge clk);
      chk("R7 valid", {31'b0, out_valid}, {31'b0, in_valid});
      chk("R7 word", out_instr, in_instr);
      chk("R7 ready", {31'b0, in_ready}, {31'b0, out_ready});
      chk("R7 dummy", {31'b0, out_dummy}, 32'd0);
      step();
    end
    in_valid = 1'b0; en = 1'b1; out_ready = 1'b1;
    step();
    run_instr(32'hD000_0001, 1, 1, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule